// File: doc/BRIEF.md
# Programmable-Tick Line Glitch Filter

This block cleans the asynchronous input of a single-wire, open-drain bus before a protocol engine samples it. The raw line first passes through a two-flop synchronizer. A small state machine then compares the synchronized level with the filtered output. The output takes the new level only after the line has held it for a programmable number of timing ticks. A burst shorter than that window never reaches the protocol engine.

The tick comes from a chain of single-cycle strobes that the block derives from the system clock. With the default parameters and a 24 MHz clock, the four strobes have periods of 125 ns, 1 µs, 10 µs and 100 µs. A 16-bit control word picks one strobe and a 3-bit delay `d`. The qualifying time is `d × 3` ticks, so a 1 µs tick with `d = 7` discards pulses shorter than 21 µs. When `d = 0` the synchronized line passes straight through. A soft-reset bit in the same word holds the output at the idle (high) level.

The state machine has three states. `ST_HOLD` means the output agrees with the line. `ST_QUALIFY` means a mismatch is being timed. `ST_FORCED` is the soft reset. The transitions are:
- `hold_to_qualify`: a mismatch is seen and `d ≠ 0`.
- `hold_flip`: a mismatch is seen with `d = 0`, so the output takes the new level at once.
- `qualify_abort`: the line returns to the output level, and the counter is cleared.
- `qualify_accept`: the `d × 3`-th tick arrives, the output flips and the machine returns to hold.
- `any_to_forced`: the soft reset is set.
- `forced_release`: the soft reset is cleared, and the machine goes to hold.

Top module: `line_glitch_filter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `line_clean` is 1 (the idle level).
- R2: With the delay field equal to 0, a level change on `line_raw` appears on `line_clean` 2 to 4 clock cycles after it is driven. This holds even for a pulse one cycle wide.
- R3: The control word fields are: delay in `cfg_word[14:12]`, tick select in `cfg_word[9:8]`, soft reset in `cfg_word[0]`. All other bits have no effect on the output.
- R4: Tick select 0 gives a period of `BASE_DIV` clocks, 1 gives `MICRO_DIV` clocks, 2 gives `MICRO_DIV×DECADE` clocks and 3 gives `MICRO_DIV×DECADE²` clocks. Each strobe is high for a single cycle.
- R5: With delay `d > 0` and tick period `P`, a pulse lasting at most `(3d−1)×P − 1` cycles produces no output edge. An output flip is always caused by a tick in the previous cycle.
- R6: A level held steadily with `d > 0` appears on `line_clean` between `(3d−1)×P + 2` and `3d×P + 3` cycles after it is driven.
- R7: The tick count restarts whenever the synchronized line equals the output. Two short pulses separated by a gap of at least one cycle do not add up to a flip.
- R8: When the soft reset is set, `line_clean` goes to 1 on the next clock and ignores `line_raw` while the bit stays set. After release, a differing line is qualified again from zero.
- R9: Outside the soft reset, every change of `line_clean` takes the value the synchronized line had in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_raw | input | 1 | Asynchronous bus line, idle high |
| cfg_word | input | 16 | Control word: delay [14:12], tick select [9:8], soft reset [0] |
| line_clean | output | 1 | Filtered line, high after reset |

## Verification
A wrong internal state shows up as a wrong edge on `line_clean`, or as an edge at the wrong time. A stale tick count either lets a short pulse through or delays a valid edge past its window. The error becomes visible within one qualifying window, at most `3d×P + 3` cycles after the stimulus. A wrong tick select or divider shifts each accepted edge by whole tick periods, so the edge falls outside the expected window for that select value. A state machine stuck in the forced state keeps the output high. This shows up on the first accepted edge after the soft reset is released.

// File: rtl/lgf_pkg.sv
package lgf_pkg;

    // Control word layout; positions are decoded by the register block above.
    localparam int CFG_W    = 16;
    localparam int SRST_BIT = 0;
    localparam int SEL_LSB  = 8;
    localparam int SEL_W    = 2;
    localparam int DEL_LSB  = 12;
    localparam int DEL_W    = 3;

    localparam int NUM_TICKS = 2 ** SEL_W;
    localparam int DEL_MUL   = 3;

    localparam logic [CFG_W-1:0] USED_MASK =
        CFG_W'((1 << SRST_BIT) |
               (((1 << SEL_W) - 1) << SEL_LSB) |
               (((1 << DEL_W) - 1) << DEL_LSB));

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_QUALIFY = 2'd1,
        ST_FORCED  = 2'd2
    } lgf_state_e;

endpackage

// File: rtl/lgf_sync.sv
module lgf_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/lgf_div_stage.sv
module lgf_div_stage #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic strobe_o
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign strobe_o = en_i && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (en_i) begin
            cnt_q <= strobe_o ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/lgf_tick_gen.sv
module lgf_tick_gen #(
    parameter int BASE_DIV    = 3,
    parameter int MICRO_DIV   = 24,
    parameter int DECADE      = 10,
    parameter int NUM_DECADES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    output logic [NUM_DECADES+1:0] ticks_o
);

    logic [NUM_DECADES+1:0] strb;

    // Fastest strobe: a few system clocks.
    lgf_div_stage #(.DIV(BASE_DIV)) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (1'b1),
        .strobe_o (strb[0])
    );

    // Microsecond-scale strobe, counted directly on the clock.
    lgf_div_stage #(.DIV(MICRO_DIV)) u_micro (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (1'b1),
        .strobe_o (strb[1])
    );

    // Each decade stage counts strobes of the stage below it.
    for (genvar g = 0; g < NUM_DECADES; g++) begin : g_decade
        lgf_div_stage #(.DIV(DECADE)) u_dec (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_i     (strb[g+1]),
            .strobe_o (strb[g+2])
        );
    end

    assign ticks_o = strb;

endmodule

// File: rtl/lgf_filter_fsm.sv
module lgf_filter_fsm
    import lgf_pkg::*;
#(
    parameter int DW = DEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst_i,
    input  logic          tick_i,
    input  logic          sync_i,
    input  logic [DW-1:0] delay_i,
    output logic          line_o
);

    localparam int MAX_TARGET = ((2 ** DW) - 1) * DEL_MUL;
    localparam int CNT_W      = $clog2(MAX_TARGET + 1);

    lgf_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             out_q, out_d;
    logic [CNT_W-1:0] target;
    logic [CNT_W:0]   cnt_next;
    logic             differ;
    logic             reached;

    assign target   = CNT_W'(delay_i) * CNT_W'(DEL_MUL);
    assign differ   = (sync_i != out_q);
    assign cnt_next = {1'b0, cnt_q} + 1'b1;
    assign reached  = tick_i && (cnt_next >= {1'b0, target});

    // Next-state and next-count logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        out_d   = out_q;
        unique case (state_q)
            ST_FORCED: begin
                out_d = 1'b1;
                cnt_d = '0;
                if (!soft_rst_i) begin
                    state_d = ST_HOLD;                    // forced_release
                end
            end
            ST_HOLD: begin
                cnt_d = '0;
                if (differ) begin
                    if (target == '0) begin
                        out_d = sync_i;                   // hold_flip
                    end else begin
                        state_d = ST_QUALIFY;             // hold_to_qualify
                        cnt_d   = tick_i ? CNT_W'(1) : '0;
                    end
                end
            end
            ST_QUALIFY: begin
                if (!differ) begin
                    state_d = ST_HOLD;                    // qualify_abort
                    cnt_d   = '0;
                end else if ((target == '0) || reached) begin
                    state_d = ST_HOLD;                    // qualify_accept
                    out_d   = sync_i;
                    cnt_d   = '0;
                end else if (tick_i) begin
                    cnt_d = cnt_next[CNT_W-1:0];
                end
            end
            default: begin
                state_d = ST_FORCED;
                out_d   = 1'b1;
                cnt_d   = '0;
            end
        endcase
        if (soft_rst_i) begin
            state_d = ST_FORCED;                          // any_to_forced
            out_d   = 1'b1;
            cnt_d   = '0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
            out_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            out_q   <= out_d;
        end
    end

    // Output
    always_comb begin
        line_o = out_q;
    end

endmodule

// File: rtl/line_glitch_filter.sv
module line_glitch_filter
    import lgf_pkg::*;
#(
    parameter int BASE_DIV  = 3,
    parameter int MICRO_DIV = 24,
    parameter int DECADE    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_raw,
    input  logic [CFG_W-1:0] cfg_word,
    output logic             line_clean
);

    localparam int NUM_DECADES = NUM_TICKS - 2;

    logic [NUM_TICKS-1:0] ticks;
    logic [SEL_W-1:0]     tick_sel;
    logic [DEL_W-1:0]     delay;
    logic                 soft_rst;
    logic                 tick;
    logic                 sync_q;
    logic                 unused_cfg_bits;

    assign soft_rst        = cfg_word[SRST_BIT];
    assign tick_sel        = cfg_word[SEL_LSB +: SEL_W];
    assign delay           = cfg_word[DEL_LSB +: DEL_W];
    assign unused_cfg_bits = ^(cfg_word & ~USED_MASK);

    lgf_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (line_raw),
        .q_o   (sync_q)
    );

    lgf_tick_gen #(
        .BASE_DIV    (BASE_DIV),
        .MICRO_DIV   (MICRO_DIV),
        .DECADE      (DECADE),
        .NUM_DECADES (NUM_DECADES)
    ) u_ticks (
        .clk     (clk),
        .rst_n   (rst_n),
        .ticks_o (ticks)
    );

    assign tick = ticks[tick_sel];

    lgf_filter_fsm #(.DW(DEL_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst_i (soft_rst),
        .tick_i     (tick),
        .sync_i     (sync_q),
        .delay_i    (delay),
        .line_o     (line_clean)
    );

endmodule

// File: rtl/lgf_checker.sv
module lgf_checker
    import lgf_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 soft_rst,
    input logic                 tick,
    input logic                 sync_v,
    input logic [DEL_W-1:0]     delay,
    input logic [NUM_TICKS-1:0] ticks,
    input logic                 line_clean
);

    // R1: idle level held during reset
    always @(negedge clk) begin
        if (!rst_n) begin
            a_r1_reset_high: assert (line_clean == 1'b1);
        end
    end

    // R8: soft reset drives the idle level on the next clock
    a_r8_forced_high: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> line_clean);

    // R9: a normal flip takes the synchronized value of the previous cycle
    a_r9_flip_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
        ((line_clean != $past(line_clean)) && !$past(soft_rst))
            |-> (line_clean == $past(sync_v)));

    // R5: with a nonzero delay, only a tick can complete a qualification
    a_r5_flip_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ((line_clean != $past(line_clean)) && !$past(soft_rst) && ($past(delay) != '0))
            |-> $past(tick));

    // R4: the fastest two strobes are single-cycle pulses
    a_r4_base_single: assert property (@(posedge clk) disable iff (!rst_n)
        ticks[0] |=> !ticks[0]);

    a_r4_micro_single: assert property (@(posedge clk) disable iff (!rst_n)
        ticks[1] |=> !ticks[1]);

endmodule

bind line_glitch_filter lgf_checker u_lgf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .tick       (tick),
    .sync_v     (sync_q),
    .delay      (delay),
    .ticks      (ticks),
    .line_clean (line_clean)
);

// File: tb/line_glitch_filter_bench.sv
module line_glitch_filter_bench;

    localparam int BASE  = 3;
    localparam int MICRO = 6;
    localparam int DEC   = 3;

    typedef struct {
        logic   lvl;
        int     lo;
        int     hi;
        longint t0;
        string  req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        line_raw = 1'b1;
    logic [15:0] cfg_word = 16'h0000;
    logic        line_clean;

    int   n_checks = 0;
    int   n_fail   = 0;
    exp_t sb_q[$];

    line_glitch_filter #(
        .BASE_DIV  (BASE),
        .MICRO_DIV (MICRO),
        .DECADE    (DEC)
    ) u_line_glitch_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_raw   (line_raw),
        .cfg_word   (cfg_word),
        .line_clean (line_clean)
    );

    always #5 clk = ~clk;

    function automatic int period(int sel);
        case (sel)
            0:       return BASE;
            1:       return MICRO;
            2:       return MICRO * DEC;
            default: return MICRO * DEC * DEC;
        endcase
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push_exp(logic lvl, int lo, int hi, string req);
        exp_t e;
        e.lvl = lvl;
        e.lo  = lo;
        e.hi  = hi;
        e.t0  = longint'($time);
        e.req = req;
        sb_q.push_back(e);
    endtask

    // R3: delay [14:12], tick select [9:8], soft reset [0]
    task automatic set_cfg(int d, int sel, bit srst);
        @(negedge clk);
        cfg_word = {1'b0, 3'(d), 2'b00, 2'(sel), 7'b0, srst};
    endtask

    task automatic drive(logic lvl);
        @(negedge clk);
        line_raw = lvl;
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain(int limit);
        for (int i = 0; i < limit && sb_q.size() != 0; i++) @(negedge clk);
        chk(sb_q.size() == 0, "R6", "pending edges", sb_q.size(), 0);
    endtask

    // A level held steadily must appear inside its qualifying window.
    task automatic accept(logic lvl, int d, int sel, string req);
        int p = period(sel);
        int lo = (d == 0) ? 2 : (3 * d - 1) * p + 2;
        int hi = (d == 0) ? 4 : 3 * d * p + 3;
        drive(lvl);
        push_exp(lvl, lo, hi, req);
        drain(hi + 10);
        settle(3);
        chk(line_clean == lvl, req, "level after accept", int'(line_clean), int'(lvl));
    endtask

    // A pulse one cycle short of any possible qualification must vanish.
    task automatic reject(logic lvl, int d, int sel, string req);
        int p = period(sel);
        int w = (3 * d - 1) * p - 1;
        logic idle = ~lvl;
        drive(lvl);
        settle(w - 1);
        drive(idle);
        settle(3 * d * p + 8);
        chk(line_clean == idle, req, "level after short pulse", int'(line_clean), int'(idle));
    endtask

    // Monitor: pop one expected item per observed output edge.
    initial begin : monitor
        logic prev = 1'b1;
        forever begin
            @(negedge clk);
            if (rst_n && (line_clean !== prev)) begin
                longint el;
                exp_t e;
                prev = line_clean;
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R5", "unexpected output edge to", int'(line_clean), int'(~line_clean));
                end else begin
                    e  = sb_q.pop_front();
                    el = (longint'($time) - e.t0) / 10;
                    chk(line_clean == e.lvl, e.req, "edge level", int'(line_clean), int'(e.lvl));
                    chk((el >= e.lo) && (el <= e.hi), e.req, "edge latency (lo bound expected)",
                        int'(el), e.lo);
                end
            end
        end
    end

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : driver
        #2 rst_n = 1'b0;
        settle(4);
        chk(line_clean == 1'b1, "R1", "output during reset", int'(line_clean), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(line_clean == 1'b1, "R1", "output after reset", int'(line_clean), 1);

        // R2: passthrough with delay 0
        set_cfg(0, 0, 1'b0);
        accept(1'b0, 0, 0, "R2");
        accept(1'b1, 0, 0, "R2");
        drive(1'b0);
        push_exp(1'b0, 2, 4, "R2");
        drive(1'b1);
        push_exp(1'b1, 2, 4, "R2");
        drain(20);

        // R3: bits outside the three fields change nothing
        @(negedge clk);
        cfg_word = 16'h8CFE;
        accept(1'b0, 0, 0, "R3");
        accept(1'b1, 0, 0, "R3");

        // R5 / R6 at each tick select
        set_cfg(1, 0, 1'b0);
        reject(1'b0, 1, 0, "R5");
        accept(1'b0, 1, 0, "R6");
        reject(1'b1, 1, 0, "R5");
        accept(1'b1, 1, 0, "R6");

        set_cfg(2, 1, 1'b0);
        reject(1'b0, 2, 1, "R5");
        accept(1'b0, 2, 1, "R4");
        accept(1'b1, 2, 1, "R4");

        set_cfg(1, 2, 1'b0);
        reject(1'b0, 1, 2, "R5");
        accept(1'b0, 1, 2, "R4");
        accept(1'b1, 1, 2, "R4");

        set_cfg(7, 3, 1'b0);
        reject(1'b0, 7, 3, "R5");
        accept(1'b0, 7, 3, "R4");

        // R8: soft reset while the output is low
        set_cfg(7, 3, 1'b1);
        push_exp(1'b1, 1, 2, "R8");
        drain(10);
        set_cfg(0, 0, 1'b1);
        drive(1'b1);
        settle(6);
        drive(1'b0);
        settle(10);
        chk(line_clean == 1'b1, "R8", "output while forced", int'(line_clean), 1);
        set_cfg(1, 0, 1'b0);
        push_exp(1'b0, (3 - 1) * BASE, 3 * BASE + 3, "R8");
        drain(40);
        accept(1'b1, 1, 0, "R8");

        // R7: two short pulses with a gap never add up
        set_cfg(2, 0, 1'b0);
        drive(1'b0);
        settle((3 * 2 - 1) * BASE - 2);
        drive(1'b1);
        settle(3);
        drive(1'b0);
        settle((3 * 2 - 1) * BASE - 2);
        drive(1'b1);
        settle(40);
        chk(line_clean == 1'b1, "R7", "output after split pulses", int'(line_clean), 1);

        settle(5);
        chk(sb_q.size() == 0, "R6", "leftover expectations", sb_q.size(), 0);
        finish_run();
    end

endmodule